// File: doc/BRIEF.md
# System Reset Combiner with Sticky Cause Flags

This block gathers every reset request of a chip into a single system reset and keeps a record, one flag per kind of reset, of which requests have fired. The sources are a power-up detect, brown-out, an active-low external clear pin, a software reset strobe, a watchdog expiry, a configuration-mismatch flag, a trap-conflict flag, and three illegal-condition inputs. The illegal-condition inputs are an illegal opcode, a read of an uninitialised working register and a security violation. All three share one flag.

The external pin is asynchronous. It is first synchronised and then debounced, so a short glitch cannot reset the chip. Once a request has been seen, the system reset is held for a fixed number of clocks after the last request goes away, and it is then released on a clock edge. The flags are sticky. Software can set or clear any of them through a masked write port without causing a reset. A power-up event wipes every flag except its own.

Top module: `sys_reset_hub`

## Requirements
- R1: While any source requests a reset at a clock edge, `sys_rst_o` is 1 after that edge.
- R2: After the last edge that samples a request, `sys_rst_o` stays 1 for a further HOLD_CYC (16) edges and then falls on a clock edge. A one-cycle request therefore gives exactly 17 cycles of reset.
- R3: Hardware sets a flag on the same edge that asserts the reset for that source. The flag positions are: bit 0 power-up, bit 1 brown-out, bit 2 software, bit 3 watchdog, bit 4 external pin, bit 5 configuration mismatch, bit 6 trap conflict, bit 7 illegal condition.
- R4: Each of the three illegal-condition inputs, on its own, sets bit 7 and no other bit.
- R5: A power-up request forces `cause_o` to 8'h01. It overrides a software write and any other source in the same cycle.
- R6: A reset other than power-up sets its own flag and leaves every other flag unchanged.
- R7: A write with `reg_wr_i`=1 loads `reg_wdata_i` into the bits where `reg_wmask_i` is 1 and leaves the other bits unchanged. The write does not assert `sys_rst_o`.
- R8: When a software write clears a bit in the same cycle that hardware sets it, the bit ends up 1.
- R9: The pin passes through SYNC_STAGES (2) flops and must then read low for FILT_LEN (4) consecutive samples. A low pulse of 3 clocks is ignored, with reset and flags unchanged. A 4-clock low pulse that starts at edge A0 asserts reset after edge A0+SYNC_STAGES+FILT_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Supply-rise detect (power-up request) |
| bor_i | input | 1 | Brown-out request |
| pin_clr_n_i | input | 1 | External clear pin, active low, asynchronous |
| sw_rst_i | input | 1 | Software reset strobe |
| wdt_to_i | input | 1 | Watchdog timeout |
| cfg_mismatch_i | input | 1 | Configuration mismatch |
| trap_conflict_i | input | 1 | Trap conflict |
| illegal_op_i | input | 1 | Illegal opcode |
| uninit_reg_i | input | 1 | Uninitialised working register use |
| sec_viol_i | input | 1 | Security violation |
| reg_wr_i | input | 1 | Cause register write strobe |
| reg_wmask_i | input | 8 | Per-bit write enable |
| reg_wdata_i | input | 8 | Write data |
| sys_rst_o | output | 1 | System reset, active high |
| cause_o | output | 8 | Cause flags (read value) |

## Verification
For a direct source, the reset output and the matching flag both change on the same edge that samples the request, so the bench reads them on the falling edge that follows. The external pin takes six edges from its first low sample to the reset output: two synchroniser stages and four filter samples. The directed pin cases sample on the sixth and seventh falling edges to bracket that rise exactly. During random traffic, a bench model steps on every rising edge, keeps a history of raw pin samples, and is compared with both outputs on each falling edge. The model counts the stretch window in edges, which matches the 17-cycle pulse checked in the directed case.

// File: rtl/rst_hub_pkg.sv
package rst_hub_pkg;
    localparam int NUM_CAUSE = 8;

    typedef enum int unsigned {
        C_POR  = 0,
        C_BOR  = 1,
        C_SW   = 2,
        C_WDT  = 3,
        C_PIN  = 4,
        C_CFG  = 5,
        C_TRAP = 6,
        C_ILL  = 7
    } cause_idx_e;

    typedef logic [NUM_CAUSE-1:0] cause_vec_t;
endpackage

// File: rtl/pin_deglitch.sv
module pin_deglitch #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic clr_i,
    input  logic pin_n_i,
    output logic pin_req_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
        logic                   act;
    } filt_st_t;

    filt_st_t st_d, st_q;
    logic     lo;

    assign lo = ~st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d = st_q;
        st_d.sync[0] = pin_n_i;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        if (lo) begin
            if (st_q.cnt != CW'(FILT_LEN)) begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
            st_d.act = (st_d.cnt == CW'(FILT_LEN));
        end else begin
            st_d.cnt = '0;
            st_d.act = 1'b0;
        end
        if (clr_i) begin
            st_d.sync = '1;
            st_d.cnt  = '0;
            st_d.act  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pin_req_o = st_q.act;

    // R9: a high synchronised sample withdraws the request on the next edge
    p_high_drops_r9: assert property (@(posedge clk) disable iff (clr_i)
        !lo |=> !st_q.act);
    // R9: the request can only start after a low synchronised sample
    p_rise_needs_low_r9: assert property (@(posedge clk) disable iff (clr_i)
        $rose(st_q.act) |-> $past(lo));
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
    parameter int NUM_SRC  = 8,
    parameter int HOLD_CYC = 16
) (
    input  logic               clk,
    input  logic               clr_i,
    input  logic [NUM_SRC-1:0] req_i,
    output logic               rst_o
);
    localparam int HW = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        logic [HW-1:0] hold;
        logic          rst;
    } str_st_t;

    str_st_t st_d, st_q;
    logic    any_req;

    assign any_req = |req_i;

    always_comb begin
        st_d = st_q;
        if (any_req || clr_i) begin
            st_d.hold = HW'(HOLD_CYC);
            st_d.rst  = 1'b1;
        end else if (st_q.hold != '0) begin
            st_d.hold = st_q.hold - HW'(1);
            st_d.rst  = 1'b1;
        end else begin
            st_d.rst  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rst_o = st_q.rst;

    p_src_asserts_r1: assert property (@(posedge clk) disable iff (clr_i)
        any_req |=> rst_o);
    p_hold_window_r2: assert property (@(posedge clk) disable iff (clr_i)
        (st_q.hold != '0) |=> rst_o);
    p_release_quiet_r2: assert property (@(posedge clk) disable iff (clr_i)
        $fell(rst_o) |-> !$past(any_req));
endmodule

// File: rtl/cause_reg.sv
module cause_reg #(
    parameter int NUM_CAUSE = 8
) (
    input  logic                 clk,
    input  logic                 por_i,
    input  logic [NUM_CAUSE-1:0] set_i,
    input  logic                 wr_i,
    input  logic [NUM_CAUSE-1:0] wmask_i,
    input  logic [NUM_CAUSE-1:0] wdata_i,
    output logic [NUM_CAUSE-1:0] cause_o
);
    typedef struct packed {
        logic [NUM_CAUSE-1:0] flags;
    } cr_st_t;

    cr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.flags = (st_q.flags & ~wmask_i) | (wdata_i & wmask_i);
        end
        st_d.flags = st_d.flags | set_i;
        if (por_i) begin
            st_d.flags = NUM_CAUSE'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cause_o = st_q.flags;

    generate
        for (genvar g = 0; g < NUM_CAUSE; g++) begin : g_bit
            // R3 / R8: a hardware set always lands
            p_hw_set_r3: assert property (@(posedge clk) disable iff (por_i)
                set_i[g] |=> cause_o[g]);
        end
    endgenerate

    p_por_wipe_r5: assert property (@(posedge clk)
        por_i |=> (cause_o == NUM_CAUSE'(1)));
    p_sticky_r6: assert property (@(posedge clk) disable iff (por_i)
        (!wr_i && set_i == '0) |=> $stable(cause_o));
    p_sw_write_r7: assert property (@(posedge clk) disable iff (por_i)
        (wr_i && (set_i & wmask_i) == '0) |=>
        ((cause_o & $past(wmask_i)) == ($past(wdata_i) & $past(wmask_i))));
endmodule

// File: rtl/sys_reset_hub.sv
module sys_reset_hub
    import rst_hub_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4,
    parameter int HOLD_CYC    = 16
) (
    input  logic       clk,
    input  logic       por_i,
    input  logic       bor_i,
    input  logic       pin_clr_n_i,
    input  logic       sw_rst_i,
    input  logic       wdt_to_i,
    input  logic       cfg_mismatch_i,
    input  logic       trap_conflict_i,
    input  logic       illegal_op_i,
    input  logic       uninit_reg_i,
    input  logic       sec_viol_i,
    input  logic       reg_wr_i,
    input  logic [7:0] reg_wmask_i,
    input  logic [7:0] reg_wdata_i,
    output logic       sys_rst_o,
    output logic [7:0] cause_o
);
    logic       pin_req;
    cause_vec_t req;

    pin_deglitch #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_pin (
        .clk       (clk),
        .clr_i     (por_i),
        .pin_n_i   (pin_clr_n_i),
        .pin_req_o (pin_req)
    );

    always_comb begin
        req         = '0;
        req[C_POR]  = por_i;
        req[C_BOR]  = bor_i;
        req[C_SW]   = sw_rst_i;
        req[C_WDT]  = wdt_to_i;
        req[C_PIN]  = pin_req;
        req[C_CFG]  = cfg_mismatch_i;
        req[C_TRAP] = trap_conflict_i;
        req[C_ILL]  = illegal_op_i | uninit_reg_i | sec_viol_i;
    end

    rst_stretch #(.NUM_SRC(NUM_CAUSE), .HOLD_CYC(HOLD_CYC)) u_str (
        .clk   (clk),
        .clr_i (por_i),
        .req_i (req),
        .rst_o (sys_rst_o)
    );

    cause_reg #(.NUM_CAUSE(NUM_CAUSE)) u_cause (
        .clk     (clk),
        .por_i   (por_i),
        .set_i   (req),
        .wr_i    (reg_wr_i),
        .wmask_i (reg_wmask_i),
        .wdata_i (reg_wdata_i),
        .cause_o (cause_o)
    );

    // R4: the illegal-condition group lands on bit 7
    p_ill_group_r4: assert property (@(posedge clk) disable iff (por_i)
        (illegal_op_i || uninit_reg_i || sec_viol_i) |=> cause_o[7]);
endmodule

// File: tb/sys_reset_hub_tb.sv
module sys_reset_hub_tb;
    localparam int HOLD = 16;

    logic clk = 1'b0;
    logic por, bor, pin_n, sw, wdt, cfg, trap, ill, uninit, sec, wr;
    logic [7:0] wmask, wdata;
    logic sys_rst;
    logic [7:0] cause;

    int n_chk = 0;
    int n_err = 0;
    bit cmp_en = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sys_reset_hub u_dut (
        .clk(clk), .por_i(por), .bor_i(bor), .pin_clr_n_i(pin_n), .sw_rst_i(sw),
        .wdt_to_i(wdt), .cfg_mismatch_i(cfg), .trap_conflict_i(trap),
        .illegal_op_i(ill), .uninit_reg_i(uninit), .sec_viol_i(sec),
        .reg_wr_i(wr), .reg_wmask_i(wmask), .reg_wdata_i(wdata),
        .sys_rst_o(sys_rst), .cause_o(cause)
    );

    // ---------------- bench model ----------------
    logic [7:0] m_cause = 8'h00;
    int         m_hold  = 0;
    logic       m_rst   = 1'b0;
    logic       hist [1:6];

    function automatic logic [7:0] apply_write(logic [7:0] cur, logic [7:0] m, logic [7:0] d);
        return (cur & ~m) | (d & m);
    endfunction

    function automatic logic [7:0] req_vec(logic pin_req);
        return {ill | uninit | sec, trap, cfg, pin_req, wdt, sw, bor, por};
    endfunction

    initial for (int j = 1; j <= 6; j++) hist[j] = 1'b1;

    always @(posedge clk) begin
        logic pin_req;
        logic [7:0] r;
        pin_req = !hist[3] && !hist[4] && !hist[5] && !hist[6];
        r = req_vec(pin_req);
        if (por) m_cause = 8'h01;
        else begin
            if (wr) m_cause = apply_write(m_cause, wmask, wdata);
            m_cause = m_cause | r;
        end
        if (r != 0) begin m_hold = HOLD; m_rst = 1'b1; end
        else if (m_hold > 0) begin m_hold--; m_rst = 1'b1; end
        else m_rst = 1'b0;
        for (int j = 6; j > 1; j--) hist[j] = hist[j-1];
        hist[1] = pin_n;
        if (por) for (int j = 1; j <= 6; j++) hist[j] = 1'b1;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            check("R1/R2 model", {31'd0, sys_rst}, {31'd0, m_rst});
            check("R3/R6/R7 model", {24'd0, cause}, {24'd0, m_cause});
        end
    end

    task automatic cyc(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic sw_write(logic [7:0] m, logic [7:0] d);
        wr = 1'b1; wmask = m; wdata = d;
        cyc();
        wr = 1'b0; wmask = 8'h00; wdata = 8'h00;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int n;
        logic [7:0] c0;
        por = 1; bor = 0; pin_n = 1; sw = 0; wdt = 0; cfg = 0; trap = 0;
        ill = 0; uninit = 0; sec = 0; wr = 0; wmask = 0; wdata = 0;
        void'($urandom(32'd1234));
        cyc(3);
        por = 0;
        cmp_en = 1;
        // R5 reset state
        check("R5 reset cause", {24'd0, cause}, 32'h01);
        check("R1 reset active", {31'd0, sys_rst}, 32'd1);
        cyc(25);
        check("R2 released", {31'd0, sys_rst}, 32'd0);

        // R7 masked writes, no reset
        sw_write(8'hFF, 8'hA5);
        check("R7 write full", {24'd0, cause}, 32'hA5);
        check("R7 no reset", {31'd0, sys_rst}, 32'd0);
        sw_write(8'h0F, 8'h00);
        check("R7 write masked", {24'd0, cause}, 32'hA0);

        // R2 stretch length and R3 bit position
        sw_write(8'hFF, 8'h00);
        wdt = 1; cyc(); wdt = 0;
        check("R3 watchdog bit", {24'd0, cause}, 32'h08);
        n = 0;
        while (sys_rst && n < 100) begin n++; cyc(); end
        check("R2 stretch cycles", n, HOLD + 1);

        // R6 sticky
        bor = 1; cyc(); bor = 0;
        check("R6 sticky", {24'd0, cause}, 32'h0A);
        cyc(20);

        // R4 illegal group
        for (int k = 0; k < 3; k++) begin
            sw_write(8'hFF, 8'h00);
            ill = (k == 0); uninit = (k == 1); sec = (k == 2);
            cyc();
            ill = 0; uninit = 0; sec = 0;
            check("R4 illegal group", {24'd0, cause}, 32'h80);
        end
        cyc(20);

        // R8 hardware set beats software clear
        wr = 1; wmask = 8'hFF; wdata = 8'h00; sw = 1;
        cyc();
        wr = 0; wmask = 0; sw = 0;
        check("R8 hw wins", {24'd0, cause}, 32'h04);
        check("R1 sw reset", {31'd0, sys_rst}, 32'd1);
        cyc(20);

        // R5 power-up overrides write and others
        sw_write(8'hFF, 8'hFF);
        por = 1; wdt = 1; wr = 1; wmask = 8'hFF; wdata = 8'h7E;
        cyc();
        por = 0; wdt = 0; wr = 0; wmask = 0; wdata = 0;
        check("R5 power-up wipe", {24'd0, cause}, 32'h01);
        cyc(25);

        // R9 short pulse ignored
        c0 = cause;
        pin_n = 0; cyc(3); pin_n = 1;
        n = 0;
        for (int k = 0; k < 20; k++) begin cyc(); if (sys_rst) n++; end
        check("R9 short pulse no reset", n, 0);
        check("R9 short pulse flags", {24'd0, cause}, {24'd0, c0});

        // R9 4-clock pulse, exact latency
        pin_n = 0; cyc(4); pin_n = 1;
        cyc(2);
        check("R9 before latency", {31'd0, sys_rst}, 32'd0);
        cyc();
        check("R9 at latency", {31'd0, sys_rst}, 32'd1);
        check("R9 pin flag", {24'd0, cause}, {24'd0, c0 | 8'h10});
        cyc(25);

        // random traffic against the model
        for (int t = 0; t < 4000; t++) begin
            int hold_pin;
            sw     = ($urandom_range(0, 39) == 0);
            wdt    = ($urandom_range(0, 59) == 0);
            bor    = ($urandom_range(0, 79) == 0);
            cfg    = ($urandom_range(0, 79) == 0);
            trap   = ($urandom_range(0, 79) == 0);
            ill    = ($urandom_range(0, 119) == 0);
            uninit = ($urandom_range(0, 119) == 0);
            sec    = ($urandom_range(0, 119) == 0);
            por    = ($urandom_range(0, 499) == 0);
            wr     = ($urandom_range(0, 5) == 0);
            wmask  = 8'($urandom);
            wdata  = 8'($urandom);
            if ($urandom_range(0, 5) == 0) begin
                hold_pin = $urandom_range(0, 1);
                pin_n = hold_pin[0];
            end
            cyc();
        end
        sw = 0; wdt = 0; bor = 0; cfg = 0; trap = 0; ill = 0; uninit = 0;
        sec = 0; por = 0; wr = 0; pin_n = 1;
        cyc(30);
        finish_run();
    end
endmodule